// File: doc/BRIEF.md
# PCIe Configuration Window Decoder

This block keeps the 64-bit base-address register that places the memory-mapped PCIe configuration space in the host address map, and checks host memory addresses against the window it defines. Software updates the register through a write port with one enable per byte lane. From the register value the block derives three things: whether the window is live, how long it is, and its base address. The base address is aligned to the window length.

A small three-state machine classifies the register after every write. The states are `WS_OFF` (valid length, enable clear), `WS_ON` (valid length, enable set) and `WS_RSVD` (reserved length code). On every write strobe the machine moves to whichever of the three states the merged register value selects, and that includes staying in its current state. With no strobe it holds. Reset places it in the state that the default register value selects, which is `WS_OFF`.

Each memory address presented on the lookup port gives a registered result. The result says whether the address falls inside the window. On a hit it also gives the bus, device, function and register fields of the offset into the window. The block also supplies the start of the 32-bit PCI memory hole, which begins just after the window.

Top module: `cfg_window_decoder`

## Requirements
- R1: On reset the register holds `DEFAULT_BAR` (0x00000000_B0000000). The window is disabled, `win_len` reads 0x10000000, `win_base` reads 0xB0000000 and `hole_start` reads 0xB0000000.
- R2: A write with `bar_wr` high replaces exactly the bytes whose `bar_be[i]` is 1, where byte i is bits [8i+7:8i]. Other bytes keep their value. With `bar_wr` low, nothing changes.
- R3: A write strobe sampled at a clock edge is reflected on `win_en`, `win_len`, `win_base` and `hole_start` right after that edge. Before that edge these outputs still show the old value.
- R4: Register bit 0 is the enable. `win_en` is 1 only when bit 0 is set and the length code is valid.
- R5: Register bits [2:1] are the length code: 00 gives 256 MiB (0x10000000), 01 gives 128 MiB (0x08000000) and 10 gives 64 MiB (0x04000000).
- R6: Length code 11 is reserved. It forces `win_en` to 0 and `win_len` to 0 whatever bit 0 holds.
- R7: `win_base` is register bits [39:0] ANDed with a mask. The mask always admits bits [39:28]. It also admits bit 27 for 128 MiB and 64 MiB, and bit 26 for 64 MiB only. Every other bit reads 0. The reserved code uses the 256 MiB mask.
- R8: While `win_en` is 1, `hole_start` equals the low 32 bits of `win_base + win_len`. Otherwise it equals the low 32 bits of `DEFAULT_BAR`.
- R9: One cycle after `lk_valid` is sampled high, `hit_valid` is 1. `hit` is 1 only if, at that sample, the window was enabled and `win_base <= lk_addr < win_base + win_len`, using 40-bit addresses.
- R10: On a hit, with offset = `lk_addr - win_base`, `bus` = offset[27:20], `dev` = offset[19:15], `fn` = offset[14:12] and `reg_off` = offset[11:0]. On a miss all four fields are 0.
- R11: A bus number beyond the window's capacity misses. Examples are bus 128 or above in a 128 MiB window and bus 64 or above in a 64 MiB window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bar_wr | input | 1 | Register write strobe |
| bar_be | input | 8 | Byte-lane enables for the write |
| bar_wdata | input | 64 | Write data |
| win_en | output | 1 | Window enabled |
| win_len | output | 40 | Window length in bytes, 0 when reserved |
| win_base | output | 40 | Masked, aligned window base |
| hole_start | output | 32 | Start of the 32-bit PCI memory hole |
| lk_valid | input | 1 | Lookup address valid |
| lk_addr | input | 40 | Host physical address to decode |
| hit_valid | output | 1 | Lookup result valid |
| hit | output | 1 | Address falls inside the window |
| bus | output | 8 | Bus number on hit |
| dev | output | 5 | Device number on hit |
| fn | output | 3 | Function number on hit |
| reg_off | output | 12 | Register offset on hit |

## Verification
The window outputs (`win_en`, `win_len`, `win_base`, `hole_start`) change right after the edge that samples a write strobe. The bench reads them once just before that edge, to confirm they still hold the old values, and once just after it. A lookup result appears one edge after `lk_valid` is sampled, so each lookup task drives the address at a falling edge and samples the result shortly after the next rising edge. Expected values come from a byte-merged register model inside the bench, and the expected hit flag is also given explicitly for each probe.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

    // Classification of the window register
    typedef enum logic [1:0] {
        WS_OFF  = 2'd0,
        WS_ON   = 2'd1,
        WS_RSVD = 2'd2
    } win_state_e;

    // Length code held in register bits [2:1]
    typedef enum logic [1:0] {
        LEN_256M = 2'b00,
        LEN_128M = 2'b01,
        LEN_64M  = 2'b10,
        LEN_RSVD = 2'b11
    } len_code_e;

    localparam int EN_BIT   = 0;
    localparam int LEN_LSB  = 1;
    localparam int LOG_256M = 28;
    localparam int LOG_128M = 27;
    localparam int LOG_64M  = 26;

    typedef struct packed {
        logic [7:0]  bus;
        logic [4:0]  dev;
        logic [2:0]  fn;
        logic [11:0] reg_off;
    } cfg_fields_t;

    function automatic win_state_e classify(input logic [63:0] r);
        if (len_code_e'(r[LEN_LSB +: 2]) == LEN_RSVD) return WS_RSVD;
        else if (r[EN_BIT])                           return WS_ON;
        else                                          return WS_OFF;
    endfunction

endpackage

// File: rtl/cfgwin_bar_reg.sv
module cfgwin_bar_reg
    import cfgwin_pkg::*;
#(
    parameter logic [63:0] DEFAULT_BAR = 64'h0000_0000_B000_0000,
    parameter int          LANES       = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [LANES-1:0]   be,
    input  logic [LANES*8-1:0] wdata,
    output logic [LANES*8-1:0] bar_q,
    output win_state_e         state_q
);
    localparam int W = LANES * 8;
    localparam win_state_e RESET_STATE = classify(DEFAULT_BAR);

    logic [W-1:0] bar_d;
    win_state_e   state_d;

    // Byte-lane merge
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign bar_d[b*8 +: 8] = (wr && be[b]) ? wdata[b*8 +: 8] : bar_q[b*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bar_q <= DEFAULT_BAR[W-1:0];
        else if (wr) bar_q <= bar_d;
    end

    // Next-state logic: each write re-classifies the merged value
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_OFF:  if (wr) state_d = classify(bar_d);
            WS_ON:   if (wr) state_d = classify(bar_d);
            WS_RSVD: if (wr) state_d = classify(bar_d);
            default: state_d = RESET_STATE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RESET_STATE;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/cfgwin_geom.sv
module cfgwin_geom
    import cfgwin_pkg::*;
#(
    parameter int          ADDR_W      = 40,
    parameter logic [63:0] DEFAULT_BAR = 64'h0000_0000_B000_0000
) (
    input  logic [63:0]       bar_q,
    input  win_state_e        state_q,
    output logic              en,
    output logic [ADDR_W-1:0] len,
    output logic [ADDR_W-1:0] base,
    output logic [31:0]       hole
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] win_end;
    logic              unused_hi;

    assign unused_hi = ^bar_q[63:ADDR_W];

    // Length and compare mask from the length code
    always_comb begin
        mask = '0;
        mask[ADDR_W-1:LOG_256M] = '1;
        len  = '0;
        unique case (len_code_e'(bar_q[LEN_LSB +: 2]))
            LEN_256M: len = ONE << LOG_256M;
            LEN_128M: begin
                mask[LOG_128M] = 1'b1;
                len = ONE << LOG_128M;
            end
            LEN_64M: begin
                mask[LOG_128M] = 1'b1;
                mask[LOG_64M]  = 1'b1;
                len = ONE << LOG_64M;
            end
            LEN_RSVD: len = '0;
            default:  len = '0;
        endcase
    end

    assign base    = bar_q[ADDR_W-1:0] & mask;
    assign win_end = base + len;

    // Output decode from the state
    always_comb begin
        en   = 1'b0;
        hole = DEFAULT_BAR[31:0];
        unique case (state_q)
            WS_ON: begin
                en   = 1'b1;
                hole = win_end[31:0];
            end
            WS_OFF:  en = 1'b0;
            WS_RSVD: en = 1'b0;
            default: en = 1'b0;
        endcase
    end

    logic unused_end;
    assign unused_end = ^win_end[ADDR_W-1:32];

endmodule

// File: rtl/cfgwin_lookup.sv
module cfgwin_lookup
    import cfgwin_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              en,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] len,
    output logic              hit_valid,
    output logic              hit,
    output cfg_fields_t       fields
);
    logic [ADDR_W:0]   limit;
    logic [ADDR_W-1:0] off;
    logic              in_win;
    cfg_fields_t       fields_d;
    logic              unused_off;

    assign limit  = {1'b0, base} + {1'b0, len};
    assign off    = lk_addr - base;
    assign in_win = en && (lk_addr >= base) && ({1'b0, lk_addr} < limit);
    assign unused_off = ^off[ADDR_W-1:LOG_256M];

    always_comb begin
        fields_d = '0;
        if (lk_valid && in_win) begin
            fields_d.bus     = off[27:20];
            fields_d.dev     = off[19:15];
            fields_d.fn      = off[14:12];
            fields_d.reg_off = off[11:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_valid <= 1'b0;
            hit       <= 1'b0;
            fields    <= '0;
        end else begin
            hit_valid <= lk_valid;
            hit       <= lk_valid && in_win;
            fields    <= fields_d;
        end
    end

endmodule

// File: rtl/cfg_window_decoder.sv
module cfg_window_decoder
    import cfgwin_pkg::*;
#(
    parameter int          ADDR_W      = 40,
    parameter logic [63:0] DEFAULT_BAR = 64'h0000_0000_B000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bar_wr,
    input  logic [7:0]        bar_be,
    input  logic [63:0]       bar_wdata,
    output logic              win_en,
    output logic [ADDR_W-1:0] win_len,
    output logic [ADDR_W-1:0] win_base,
    output logic [31:0]       hole_start,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              hit_valid,
    output logic              hit,
    output logic [7:0]        bus,
    output logic [4:0]        dev,
    output logic [2:0]        fn,
    output logic [11:0]       reg_off
);
    logic [63:0] bar_q;
    win_state_e  state_q;
    cfg_fields_t fields;

    cfgwin_bar_reg #(.DEFAULT_BAR(DEFAULT_BAR), .LANES(8)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr(bar_wr), .be(bar_be), .wdata(bar_wdata),
        .bar_q(bar_q), .state_q(state_q)
    );

    cfgwin_geom #(.ADDR_W(ADDR_W), .DEFAULT_BAR(DEFAULT_BAR)) u_geom (
        .bar_q(bar_q), .state_q(state_q),
        .en(win_en), .len(win_len), .base(win_base), .hole(hole_start)
    );

    cfgwin_lookup #(.ADDR_W(ADDR_W)) u_lookup (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .en(win_en), .base(win_base), .len(win_len),
        .hit_valid(hit_valid), .hit(hit), .fields(fields)
    );

    assign bus     = fields.bus;
    assign dev     = fields.dev;
    assign fn      = fields.fn;
    assign reg_off = fields.reg_off;

endmodule

// File: rtl/cfgwin_checker.sv
module cfgwin_checker #(
    parameter int          ADDR_W      = 40,
    parameter logic [63:0] DEFAULT_BAR = 64'h0000_0000_B000_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bar_wr,
    input logic              win_en,
    input logic [ADDR_W-1:0] win_len,
    input logic [ADDR_W-1:0] win_base,
    input logic [31:0]       hole_start,
    input logic              lk_valid,
    input logic              hit_valid,
    input logic              hit,
    input logic [7:0]        bus,
    input logic [4:0]        dev,
    input logic [2:0]        fn,
    input logic [11:0]       reg_off
);
    // R6
    rsvd_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_len == '0) |-> !win_en);

    // R5
    len_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(win_len) <= 1);

    // R8
    hole_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_en |-> (hole_start == DEFAULT_BAR[31:0]));

    // R8
    hole_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_en |-> (hole_start == 32'(win_base[31:0] + win_len[31:0])));

    // R2
    no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bar_wr |=> ($stable(win_base) && $stable(win_len) && $stable(win_en)));

    // R9
    hit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ($past(win_en) && hit_valid));

    // R9
    hit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> hit_valid);

    // R10
    miss_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (bus == 8'd0 && dev == 5'd0 && fn == 3'd0 && reg_off == 12'd0));

endmodule

bind cfg_window_decoder cfgwin_checker #(.ADDR_W(ADDR_W), .DEFAULT_BAR(DEFAULT_BAR)) u_chk (
    .clk(clk), .rst_n(rst_n), .bar_wr(bar_wr), .win_en(win_en), .win_len(win_len),
    .win_base(win_base), .hole_start(hole_start), .lk_valid(lk_valid),
    .hit_valid(hit_valid), .hit(hit), .bus(bus), .dev(dev), .fn(fn), .reg_off(reg_off)
);

// File: tb/tb_cfg_window_decoder.sv
`timescale 1ns/1ps
module tb_cfg_window_decoder;
    localparam int          AW   = 40;
    localparam logic [63:0] DEF  = 64'h0000_0000_B000_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bar_wr = 1'b0;
    logic [7:0]    bar_be = '0;
    logic [63:0]   bar_wdata = '0;
    logic          win_en;
    logic [AW-1:0] win_len, win_base;
    logic [31:0]   hole_start;
    logic          lk_valid = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          hit_valid, hit;
    logic [7:0]    bus;
    logic [4:0]    dev;
    logic [2:0]    fn;
    logic [11:0]   reg_off;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [63:0] mreg = DEF;

    always #2.5 clk = ~clk;

    cfg_window_decoder #(.ADDR_W(AW), .DEFAULT_BAR(DEF)) dut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference model of the requirements
    function automatic logic [AW-1:0] m_len(input logic [63:0] m);
        case (m[2:1])
            2'b00: return 40'h00_1000_0000;
            2'b01: return 40'h00_0800_0000;
            2'b10: return 40'h00_0400_0000;
            default: return '0;
        endcase
    endfunction
    function automatic logic [AW-1:0] m_base(input logic [63:0] m);
        logic [AW-1:0] mk;
        mk = 40'hFF_F000_0000;
        if (m[2:1] == 2'b01) mk[27] = 1'b1;
        if (m[2:1] == 2'b10) mk[27:26] = 2'b11;
        return m[AW-1:0] & mk;
    endfunction
    function automatic logic m_en(input logic [63:0] m);
        return m[0] && (m[2:1] != 2'b11);
    endfunction
    function automatic logic [31:0] m_hole(input logic [63:0] m);
        logic [AW-1:0] e;
        e = m_base(m) + m_len(m);
        return m_en(m) ? e[31:0] : DEF[31:0];
    endfunction

    task automatic check_cfg(input string req);
        chk({req, " en"},   64'(win_en),     64'(m_en(mreg)));
        chk({req, " len"},  64'(win_len),    64'(m_len(mreg)));
        chk({req, " base"}, 64'(win_base),   64'(m_base(mreg)));
        chk({req, " hole"}, 64'(hole_start), 64'(m_hole(mreg)));
    endtask

    task automatic bar_write(input string req, input logic [7:0] be, input logic [63:0] d);
        @(negedge clk);
        bar_wr = 1'b1; bar_be = be; bar_wdata = d;
        #1;
        check_cfg("R3 before edge");
        @(posedge clk); #1;
        bar_wr = 1'b0;
        for (int b = 0; b < 8; b++) if (be[b]) mreg[b*8 +: 8] = d[b*8 +: 8];
        check_cfg(req);
    endtask

    task automatic probe(input string req, input logic [AW-1:0] a, input logic want_hit);
        logic [AW-1:0] off;
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        @(posedge clk); #1;
        lk_valid = 1'b0;
        off = a - m_base(mreg);
        chk({req, " hit_valid R9"}, 64'(hit_valid), 64'd1);
        chk({req, " hit R9"}, 64'(hit), 64'(want_hit));
        chk({req, " fields R10"}, {bus, dev, fn, reg_off},
            want_hit ? 64'({off[27:20], off[19:15], off[14:12], off[11:0]}) : 64'd0);
    endtask

    task automatic t_reset;
        check_cfg("R1 reset");
        chk("R1 reset hole", 64'(hole_start), 64'hB000_0000);
        chk("R1 reset hit_valid", 64'(hit_valid), 64'd0);
    endtask

    task automatic t_256m;
        bar_write("R4 R5 256M enable", 8'hFF, 64'h0000_0000_B000_0001);
        chk("R8 hole 256M", 64'(hole_start), 64'hC000_0000);
        probe("R10 inside", 40'hB000_0000 + (5 << 20) + (3 << 15) + (2 << 12) + 12'h044, 1'b1);
        probe("R9 below base", 40'h00_AFFF_FFFF, 1'b0);
        probe("R9 at end", 40'h00_C000_0000, 1'b0);
        probe("R9 last byte", 40'h00_BFFF_FFFF, 1'b1);
        probe("R9 base", 40'h00_B000_0000, 1'b1);
    endtask

    task automatic t_128m;
        bar_write("R5 R7 128M", 8'hFF, 64'h0000_0000_E800_0003);
        chk("R7 base bit27", 64'(win_base), 64'hE800_0000);
        chk("R8 hole 128M", 64'(hole_start), 64'hF000_0000);
        probe("R11 bus 127", 40'h00_E800_0000 + (8'd127 << 20), 1'b1);
        probe("R11 bus 128", 40'h00_E800_0000 + (8'd128 << 20), 1'b0);
    endtask

    task automatic t_64m;
        bar_write("R7 mask 256M drops bit26", 8'hFF, 64'h0000_0000_C400_0001);
        chk("R7 base 256M", 64'(win_base), 64'hC000_0000);
        bar_write("R5 R7 64M", 8'hFF, 64'h0000_0000_C400_0005);
        chk("R7 base bit26", 64'(win_base), 64'hC400_0000);
        chk("R8 hole 64M", 64'(hole_start), 64'hC800_0000);
        probe("R11 bus 63", 40'h00_C400_0000 + (8'd63 << 20) + 12'hFFC, 1'b1);
        probe("R11 bus 64", 40'h00_C400_0000 + (8'd64 << 20), 1'b0);
    endtask

    task automatic t_rsvd;
        bar_write("R6 reserved", 8'hFF, 64'h0000_0000_B000_0007);
        chk("R6 len zero", 64'(win_len), 64'd0);
        chk("R6 disabled", 64'(win_en), 64'd0);
        probe("R6 no hit", 40'h00_B000_0100, 1'b0);
    endtask

    task automatic t_lanes;
        bar_write("R2 full", 8'hFF, 64'h0000_0000_B000_0001);
        bar_write("R4 lane0 clears enable", 8'h01, 64'hFFFF_FFFF_FFFF_FF00);
        chk("R4 disabled", 64'(win_en), 64'd0);
        probe("R4 disabled no hit", 40'h00_B000_0000, 1'b0);
        bar_write("R2 lane3", 8'h08, 64'h1111_1111_D011_1111);
        chk("R2 lane3 base", 64'(win_base), 64'hD000_0000);
        bar_write("R2 lane4", 8'h10, 64'h0000_0001_0000_0000);
        bar_write("R2 lane0 enable", 8'h01, 64'h0000_0000_0000_0001);
        chk("R2 base above 4G", 64'(win_base), 64'h1_D000_0000);
        chk("R8 hole wraps low", 64'(hole_start), 64'hE000_0000);
        probe("R9 high addr hit", 40'h01_D000_0010, 1'b1);
        probe("R9 low alias miss", 40'h00_D000_0010, 1'b0);
    endtask

    task automatic t_nowrite;
        @(negedge clk);
        bar_wr = 1'b0; bar_be = 8'hFF; bar_wdata = 64'h0000_0000_1234_0001;
        @(posedge clk); #1;
        check_cfg("R2 no strobe");
        @(negedge clk);
        lk_valid = 1'b0;
        @(posedge clk); #1;
        chk("R9 idle hit_valid", 64'(hit_valid), 64'd0);
        chk("R9 idle hit", 64'(hit), 64'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_256m();
        t_128m();
        t_64m();
        t_rsvd();
        t_lanes();
        t_nowrite();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule